// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

The block is a 16-bit down-counter that gives a host a periodic interrupt. A prescaler divides the system clock into a fixed tick of `TICK_US` microseconds, which is 100 µs by default. The counter steps down by one on each tick. Software programs a start value, turns the timer on, and waits for the interrupt. When the counter passes through zero it wraps to FFFFh and keeps running. It does not reload the start value. If the interrupt enable is set, the wrap also sets a sticky status flag that drives the `irq` output.

Software reaches four registers through single-cycle writes and combinational reads, selected by `addr`:

| addr | Contents |
|------|----------|
| 0 | Control: bit 0 run, bit 1 interrupt enable |
| 1 | Start value, bits 15:0 |
| 2 | Live count, read-only |
| 3 | Status flag, bit 0, cleared by writing a one |

Turning the timer off parks the count at FFFFh. Writing a new start value while the timer runs restarts the countdown from that value at once.

Top module: `pit_timer`

## Requirements
- R1: After a synchronous active-low reset, the count (addr 2) reads FFFFh, and control, start value and status read 0, with `irq` low.
- R2: A control write that changes bit 0 from 0 to 1 loads the count from the start value. The count then falls by one every TICK_DIV clock cycles, and the first step comes TICK_DIV cycles after that write.
- R3: A control write that changes bit 0 from 1 to 0 forces the count to FFFFh. It holds there while the timer is off, and no status is set during that time, even if a tick falls in the cycle of the write.
- R4: A start-value write (addr 1) while running reloads the count from the written value in the next cycle and restarts the tick phase. While stopped, the write only stores the value, and the count stays at FFFFh.
- R5: A control write with bit 0 set while the timer is already running neither reloads the count nor shifts the tick phase.
- R6: A tick that arrives with the count at 0000h makes the count FFFFh, and counting continues from there without reloading the start value.
- R7: At a wrap, the status flag is set only if control bit 1 is 1, and `irq` equals the status flag.
- R8: The status flag is sticky. Writing 1 to bit 0 of addr 3 clears it, and writing 0 leaves it unchanged.
- R9: When a wrap with the interrupt enable set falls in the same cycle as a clearing write to addr 3, the flag ends set.
- R10: Reads have no side effects, and writes to addr 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 2 | Register select |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request, equal to the status flag |

## Verification
Two pairs of events can land on the same clock edge.

- **Wrap and status clear.** A run starts at 0000h with the interrupt enabled. The clearing write is then timed so that it lands on the edge where the zero-count tick arrives. The flag must read 1 afterwards.
- **Wrap and stop.** A stop write is placed on the edge of a zero-count tick. The count must read FFFFh and `irq` must stay low, so the stop suppresses the wrap.

// File: rtl/pit_pkg.sv
// Package pit_pkg
// Shared register map and field positions for the periodic interrupt timer.
// Assumes a 2-bit register select.
package pit_pkg;

    typedef enum logic [1:0] {
        REG_CTRL    = 2'd0,
        REG_START   = 2'd1,
        REG_COUNT   = 2'd2,
        REG_STATUS  = 2'd3
    } pit_reg_e;

    localparam int unsigned CTRL_RUN_BIT = 0;
    localparam int unsigned CTRL_IE_BIT  = 1;
    localparam int unsigned STAT_FLAG_BIT = 0;

endpackage

// File: rtl/pit_prescaler.sv
// Module pit_prescaler
// Divides the clock into a single-cycle tick every TICK_DIV cycles while
// run is high. A restart pulse zeroes the phase, so the next tick comes
// exactly TICK_DIV cycles after the restart edge. Assumes TICK_DIV >= 1.
module pit_prescaler #(
    parameter int unsigned TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);

    localparam int unsigned PS_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    generate
        if (TICK_DIV == 1) begin : g_passthru
            // Every cycle is a tick when no division is needed.
            always_comb tick = run && !restart;
        end else begin : g_divider
            localparam logic [PS_W-1:0] LAST = PS_W'(TICK_DIV - 1);
            logic [PS_W-1:0] phase_q;

            // Phase counter: cleared on reset, restart or idle, else wraps at LAST.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    phase_q <= '0;
                end else if (restart || !run) begin
                    phase_q <= '0;
                end else if (phase_q == LAST) begin
                    phase_q <= '0;
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end

            // Tick decode: last phase of a running, non-restarting cycle.
            always_comb tick = run && !restart && (phase_q == LAST);

            // Ticks never come back to back when dividing (R2).
            p_tick_spaced_r2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/pit_counter.sv
// Module pit_counter
// The down-counter itself. It is parked at all-ones while stopped, loads the
// start value on start, reloads on a live start-value write, and steps on
// each tick. It wraps from zero to all-ones and flags that wrap for one
// cycle. Assumes start, stop and load_now are mutually exclusive, because
// they come from writes to different registers.
module pit_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             start,
    input  logic             stop,
    input  logic             load_now,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] start_val,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] PARK = '1;

    logic [CNT_W-1:0] count_q;
    logic             at_zero;

    // Zero detect for the wrap decision.
    always_comb at_zero = (count_q == '0);

    // Count register: priority is stop, start, idle, reload, then tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= PARK;
        end else if (stop) begin
            count_q <= PARK;
        end else if (start) begin
            count_q <= start_val;
        end else if (!run) begin
            count_q <= PARK;
        end else if (load_now) begin
            count_q <= load_val;
        end else if (tick) begin
            count_q <= at_zero ? PARK : (count_q - 1'b1);
        end
    end

    // Wrap event: a tick at zero that is not overridden by stop or reload.
    always_comb wrap = run && tick && at_zero && !stop && !load_now;

    always_comb count = count_q;

    // Reset parks the count (R1).
    p_reset_park_r1: assert property (@(posedge clk)
        !rst_n |=> (count_q == PARK));

    // Idle without a start keeps the count parked (R3).
    p_idle_park_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start) |=> (count_q == PARK));

    // A stop parks the count in the next cycle (R3).
    p_stop_park_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (count_q == PARK));

    // Start loads the stored start value (R2).
    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (count_q == $past(start_val)));

    // A running start-value write reloads from the written data (R4).
    p_live_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_now && run && !stop) |=> (count_q == $past(load_val)));

    // A plain tick above zero steps down by one (R2).
    p_step_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !stop && !load_now && !start && count_q != '0)
        |=> (count_q == $past(count_q) - 1'b1));

    // A wrap lands on all-ones, not on the start value (R6).
    p_wrap_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count_q == PARK));

endmodule

// File: rtl/pit_irq_status.sv
// Module pit_irq_status
// Sticky interrupt flag. A gated wrap sets it and a write-one clears it;
// a set in the same cycle as a clear wins. Assumes wrap is a single-cycle
// pulse.
module pit_irq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic irq_en,
    input  logic clr_req,
    output logic flag
);

    logic flag_q;
    logic set_req;

    // A wrap only counts as an interrupt when enabled.
    always_comb set_req = wrap && irq_en;

    // Flag register: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_req) begin
            flag_q <= 1'b1;
        end else if (clr_req) begin
            flag_q <= 1'b0;
        end
    end

    always_comb flag = flag_q;

    // The flag holds unless a clear is requested (R8).
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_req) |=> flag_q);

    // A clear without a coincident enabled wrap drops the flag (R8).
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !(wrap && irq_en)) |=> !flag_q);

    // An enabled wrap always leaves the flag set, clear or not (R9).
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && irq_en) |=> flag_q);

    // The flag only rises after an enabled wrap (R7).
    p_gated_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(wrap && irq_en));

endmodule

// File: rtl/pit_timer.sv
// Module pit_timer
// Top of the periodic interrupt timer. It decodes single-cycle register
// writes into start, stop, reload and clear events. It holds the control
// and start-value registers and muxes the read data. Assumes 1e6 is a
// multiple of TICK_US and that CLK_HZ yields at least one cycle per tick.
module pit_timer #(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned TICK_US = 100,
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    import pit_pkg::*;

    localparam int unsigned TICKS_PER_SEC = 1_000_000 / TICK_US;
    localparam int unsigned RAW_DIV       = CLK_HZ / TICKS_PER_SEC;
    localparam int unsigned TICK_DIV      = (RAW_DIV < 1) ? 1 : RAW_DIV;

    logic             run_q;
    logic             ie_q;
    logic [CNT_W-1:0] start_q;
    logic             wr_ctrl, wr_start, wr_status;
    logic             ev_start, ev_stop, ev_reload, ev_clear;
    logic             tick;
    logic             wrap;
    logic             flag;
    logic [CNT_W-1:0] count;

    // Write decode per register.
    always_comb begin
        wr_ctrl   = wr_en && (addr == REG_CTRL);
        wr_start  = wr_en && (addr == REG_START);
        wr_status = wr_en && (addr == REG_STATUS);
    end

    // Event decode: run-bit edges, live reload and status clear.
    always_comb begin
        ev_start  = wr_ctrl && wdata[CTRL_RUN_BIT] && !run_q;
        ev_stop   = wr_ctrl && !wdata[CTRL_RUN_BIT] && run_q;
        ev_reload = wr_start && run_q;
        ev_clear  = wr_status && wdata[STAT_FLAG_BIT];
    end

    // Control register: run and interrupt-enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            ie_q  <= 1'b0;
        end else if (wr_ctrl) begin
            run_q <= wdata[CTRL_RUN_BIT];
            ie_q  <= wdata[CTRL_IE_BIT];
        end
    end

    // Start-value register: writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
        end else if (wr_start) begin
            start_q <= wdata[CNT_W-1:0];
        end
    end

    pit_prescaler #(
        .TICK_DIV (TICK_DIV)
    ) u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .restart (ev_start || wr_start),
        .tick    (tick)
    );

    pit_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_q),
        .start     (ev_start),
        .stop      (ev_stop),
        .load_now  (ev_reload),
        .load_val  (wdata[CNT_W-1:0]),
        .start_val (start_q),
        .tick      (tick),
        .count     (count),
        .wrap      (wrap)
    );

    pit_irq_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap    (wrap),
        .irq_en  (ie_q),
        .clr_req (ev_clear),
        .flag    (flag)
    );

    // Read mux: pure decode of addr, no state touched.
    always_comb begin
        rdata = '0;
        unique case (addr)
            REG_CTRL: begin
                rdata[CTRL_RUN_BIT] = run_q;
                rdata[CTRL_IE_BIT]  = ie_q;
            end
            REG_START:  rdata[CNT_W-1:0] = start_q;
            REG_COUNT:  rdata[CNT_W-1:0] = count;
            REG_STATUS: rdata[STAT_FLAG_BIT] = flag;
            default:    rdata = '0;
        endcase
    end

    always_comb irq = flag;

    generate
        if (DATA_W > CNT_W) begin : g_wide_bus
            logic unused_wdata_hi;
            // Upper write-data bits carry no register field.
            always_comb unused_wdata_hi = ^wdata[DATA_W-1:CNT_W];
        end
    endgenerate

    // A stop write leaves the timer off with the count parked (R3).
    p_stop_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> (!run_q && rdata_count_park()));

    // While off, the status never rises (R3).
    p_off_no_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !$past(run_q)) |-> !$rose(irq));

    // Rewriting run=1 while running keeps the count path untouched (R5).
    p_rerun_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && run_q && wdata[CTRL_RUN_BIT] && !tick) |=> $stable(count));

    function automatic logic rdata_count_park();
        return (count == {CNT_W{1'b1}});
    endfunction

endmodule

// File: tb/pit_timer_test.sv
// Bench for pit_timer with a 4-cycle tick (40 kHz clock, 100 us tick).
module pit_timer_test;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned TB_CLK_HZ  = 40_000;

    typedef struct packed {
        logic [15:0] start_val;
        logic        ie;
        logic [7:0]  wait_n;
        logic [15:0] exp_count;
        logic        exp_irq;
    } vec_t;

    // start, ie, cycles after enable, expected count, expected irq
    localparam vec_t VECS [9] = '{
        '{16'd10,     1'b0, 8'd0,  16'd10,     1'b0},
        '{16'd10,     1'b0, 8'd3,  16'd10,     1'b0},
        '{16'd10,     1'b1, 8'd4,  16'd9,      1'b0},
        '{16'd10,     1'b0, 8'd13, 16'd7,      1'b0},
        '{16'd0,      1'b1, 8'd4,  16'hFFFF,   1'b1},
        '{16'd0,      1'b0, 8'd4,  16'hFFFF,   1'b0},
        '{16'd1,      1'b1, 8'd12, 16'hFFFE,   1'b1},
        '{16'd0,      1'b1, 8'd8,  16'hFFFE,   1'b1},
        '{16'hFFFF,   1'b1, 8'd8,  16'hFFFD,   1'b0}
    };

    logic        clk;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;

    int unsigned n_checks;
    int unsigned n_bad;
    bit          finished;

    pit_timer #(
        .CLK_HZ  (TB_CLK_HZ),
        .TICK_US (100),
        .CNT_W   (16),
        .DATA_W  (32)
    ) uut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        wdata = '0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic cycles(input int unsigned n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fresh_run(input logic [15:0] sv, input logic ie);
        reg_write(2'd0, 32'd0);
        reg_write(2'd3, 32'd1);
        reg_write(2'd1, {16'd0, sv});
        reg_write(2'd0, {30'd0, ie, 1'b1});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        n_checks = 0;
        n_bad    = 0;
        finished = 1'b0;
        rst_n = 1'b0;
        wr_en = 1'b0;
        addr  = 2'd0;
        wdata = '0;
        cycles(3);
        rst_n = 1'b1;
        #1;

        // R1: reset state
        reg_read(2'd2, rd); check("R1 count", rd, 32'h0000FFFF);
        reg_read(2'd0, rd); check("R1 ctrl", rd, 32'd0);
        reg_read(2'd1, rd); check("R1 start", rd, 32'd0);
        reg_read(2'd3, rd); check("R1 status", rd, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);

        // R2 R6 R7: table walk
        foreach (VECS[i]) begin
            fresh_run(VECS[i].start_val, VECS[i].ie);
            cycles(VECS[i].wait_n);
            reg_read(2'd2, rd);
            check("R2/R6 table count", rd, {16'd0, VECS[i].exp_count});
            check("R7 table irq", {31'd0, irq}, {31'd0, VECS[i].exp_irq});
        end

        // R4: start write while stopped only stores
        reg_write(2'd0, 32'd0);
        reg_write(2'd1, 32'h1234);
        reg_read(2'd2, rd); check("R4 stopped count", rd, 32'h0000FFFF);
        reg_read(2'd1, rd); check("R4 stored start", rd, 32'h00001234);

        // R4: start write while running reloads and restarts phase
        fresh_run(16'd100, 1'b0);
        cycles(9);
        reg_read(2'd2, rd); check("R4 before reload", rd, 32'd98);
        reg_write(2'd1, 32'd50);
        reg_read(2'd2, rd); check("R4 reload", rd, 32'd50);
        cycles(3);
        reg_read(2'd2, rd); check("R4 phase hold", rd, 32'd50);
        cycles(1);
        reg_read(2'd2, rd); check("R4 phase step", rd, 32'd49);

        // R5: run=1 rewrite while running
        fresh_run(16'd100, 1'b0);
        cycles(6);
        reg_read(2'd2, rd); check("R5 before", rd, 32'd99);
        reg_write(2'd0, 32'd1);
        reg_read(2'd2, rd); check("R5 no reload", rd, 32'd99);
        cycles(1);
        reg_read(2'd2, rd); check("R5 phase kept", rd, 32'd98);

        // R3: stop while running
        fresh_run(16'h1234, 1'b1);
        cycles(5);
        reg_read(2'd2, rd); check("R3 running", rd, 32'h00001233);
        reg_write(2'd0, 32'd2);
        reg_read(2'd2, rd); check("R3 parked", rd, 32'h0000FFFF);
        cycles(20);
        reg_read(2'd2, rd); check("R3 held", rd, 32'h0000FFFF);

        // R3: stop lands on the zero tick, no wrap status
        fresh_run(16'd0, 1'b1);
        cycles(3);
        reg_write(2'd0, 32'd2);
        reg_read(2'd2, rd); check("R3 stop on tick count", rd, 32'h0000FFFF);
        check("R3 stop on tick irq", {31'd0, irq}, 32'd0);
        cycles(8);
        check("R3 off irq", {31'd0, irq}, 32'd0);

        // R8 R10: sticky flag, write-zero, ignored count write
        fresh_run(16'd0, 1'b1);
        cycles(4);
        check("R8 set", {31'd0, irq}, 32'd1);
        reg_write(2'd0, 32'd0);
        reg_write(2'd3, 32'd0);
        reg_read(2'd3, rd); check("R8 write zero", rd, 32'd1);
        reg_write(2'd2, 32'h5555);
        reg_read(2'd2, rd); check("R10 count write ignored", rd, 32'h0000FFFF);
        reg_read(2'd3, rd);
        reg_read(2'd3, rd); check("R10 read no side effect", rd, 32'd1);
        check("R7 irq follows flag", {31'd0, irq}, 32'd1);
        reg_write(2'd3, 32'd1);
        reg_read(2'd3, rd); check("R8 clear", rd, 32'd0);
        check("R8 irq low", {31'd0, irq}, 32'd0);

        // R9: clear lands on the wrap edge
        fresh_run(16'd0, 1'b1);
        cycles(3);
        reg_write(2'd3, 32'd1);
        reg_read(2'd3, rd); check("R9 set wins", rd, 32'd1);
        reg_read(2'd2, rd); check("R9 count wrapped", rd, 32'h0000FFFF);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule